// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate Unit

This unit performs the signed multiply operations used by the DSP extension of a 32-bit processor datapath. Each operation takes two 32-bit sources, a 32-bit accumulator and a 4-bit opcode. It returns a 32-bit primary result and a 32-bit upper word, which only the long multiply uses. It also maintains a sticky saturation flag. The halfword forms pick the lower or upper half of each source on its own and sign-extend it before the multiply. The accumulating forms report signed 32-bit overflow of the final value and use it to set the flag.

The operation issues with `in_valid`. With the default `REG_OUT = 1`, its results appear one clock later with `out_valid`, together with a one-cycle `q_set` pulse for that operation. The sticky `q_flag` is a register. Only reset or `q_clear` lowers it. Decode, register access and condition evaluation stay outside the unit.

Top module: `smac_unit`

## Requirements
- R1: Opcodes 1, 2, 3 and 4 are non-accumulating halfword multiplies, in the order bottom/bottom, bottom/top, top/bottom and top/top. The first letter names the half of `src_a` and the second names the half of `src_b`. Bottom is bits 15:0 and top is bits 31:16. Each half is sign-extended, and `res_lo` is the 32-bit signed product. `q_set` stays low.
- R2: Opcodes 5, 6, 7 and 8 use the same half selection as opcodes 1 to 4. They add the signed `src_acc` to the product, and `res_lo` is the low 32 bits of the sum.
- R3: An accumulating operation (opcodes 5 to 10) overflows when bit 32 of its sign-extended final value differs from bit 31. On overflow `q_set` is high with that result, and `q_flag` is 1 from the same cycle on.
- R4: `q_flag` is never lowered by an operation. It clears only on reset or on `q_clear`. When `q_clear` and an overflowing operation occur in the same cycle, the flag ends up set.
- R5: Opcode 9 (bottom) and opcode 10 (top) sign-extend one half of `src_b` and multiply it by the full signed `src_a`. They add `src_acc` widened to 64 bits and shifted left by 16. The sum is shifted arithmetically right by 16, and `res_lo` is the low 32 bits of that value.
- R6: Opcode 11 forms the 64-bit signed product of `src_a` and `src_b`. `res_lo` receives bits 31:0 and `res_hi` receives bits 63:32. `q_set` stays low.
- R7: Opcode 0 returns the low 32 bits of `src_a * src_b` in `res_lo`, and `q_set` stays low.
- R8: For every opcode other than 11, `res_hi` is zero. Opcodes 12 to 15 give zero results and never set the flag.
- R9: With `REG_OUT = 1`, `out_valid` follows `in_valid` one cycle later and carries that operation's results. When `out_valid` is low, `q_set` is low.
- R10: After synchronous reset, `out_valid`, `q_set`, `q_flag`, `res_lo` and `res_hi` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation issue strobe |
| op | input | 4 | Operation select |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| src_acc | input | 32 | Accumulator operand |
| q_clear | input | 1 | Clears the sticky flag |
| out_valid | output | 1 | Result valid |
| res_lo | output | 32 | Primary result / low product word |
| res_hi | output | 32 | High product word (long multiply) |
| q_set | output | 1 | Overflow of the delivered operation |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
Each opcode runs with small positive values, mixed-sign values, and sources whose two halves differ. This shows whether the correct half is taken and whether it is sign-extended rather than zero-extended. The accumulate paths are pushed to both overflow directions, including 0x8000 times 0x8000 plus the largest positive accumulator. The word-by-halfword form is driven with accumulators whose upper bits survive the shift, which shows whether the shifted value is widened. The flag sequence covers a set followed by non-overflowing operations, a clear with no set, and a clear that coincides with a set, which distinguishes sticky behaviour and clear priority.

// File: rtl/smac_pkg.sv
package smac_pkg;
  localparam int W      = 32;
  localparam int HW     = W / 2;
  localparam int WIDE   = 2 * W;
  localparam int OP_W   = 4;
  localparam int WSHIFT = HW;

  typedef enum logic [OP_W-1:0] {
    OP_MUL     = 4'd0,
    OP_HMUL_BB = 4'd1,
    OP_HMUL_BT = 4'd2,
    OP_HMUL_TB = 4'd3,
    OP_HMUL_TT = 4'd4,
    OP_HMAC_BB = 4'd5,
    OP_HMAC_BT = 4'd6,
    OP_HMAC_TB = 4'd7,
    OP_HMAC_TT = 4'd8,
    OP_WMAC_B  = 4'd9,
    OP_WMAC_T  = 4'd10,
    OP_LMUL    = 4'd11
  } smac_op_e;

  typedef struct packed {
    logic [W-1:0] lo;
    logic [W-1:0] hi;
    logic         ovf;
  } smac_res_t;

  // Sign-extend a word to the wide datapath.
  function automatic logic signed [WIDE-1:0] f_sx(input logic [W-1:0] v);
    return $signed({{(WIDE-W){v[W-1]}}, v});
  endfunction

  function automatic logic signed [WIDE-1:0] f_mul(input logic [W-1:0] x,
                                                   input logic [W-1:0] y);
    return f_sx(x) * f_sx(y);
  endfunction

  function automatic logic signed [WIDE-1:0] f_hmac(input logic [W-1:0] hx,
                                                    input logic [W-1:0] hy,
                                                    input logic [W-1:0] acc);
    return f_mul(hx, hy) + f_sx(acc);
  endfunction

  // Word x halfword with pre-shifted accumulator, then arithmetic shift back.
  function automatic logic signed [WIDE-1:0] f_wmac(input logic [W-1:0] x,
                                                    input logic [W-1:0] hy,
                                                    input logic [W-1:0] acc);
    logic signed [WIDE-1:0] t;
    t = f_mul(x, hy) + (f_sx(acc) <<< WSHIFT);
    return t >>> WSHIFT;
  endfunction

  // Signed 32-bit overflow: bit 32 disagrees with bit 31.
  function automatic logic f_ovf(input logic signed [WIDE-1:0] v);
    return v[W] ^ v[W-1];
  endfunction

  function automatic logic f_is_acc(input logic [OP_W-1:0] op);
    return (op >= OP_HMAC_BB) && (op <= OP_WMAC_T);
  endfunction
endpackage

// File: rtl/smac_half_pick.sv
module smac_half_pick
  import smac_pkg::*;
(
  input  logic [W-1:0] word,
  input  logic         take_top,
  output logic [W-1:0] ext
);
  logic [HW-1:0] half;

  always_comb begin
    half = take_top ? word[W-1:HW] : word[HW-1:0];
    ext  = {{(W-HW){half[HW-1]}}, half};
  end
endmodule

// File: rtl/smac_core.sv
module smac_core
  import smac_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [W-1:0]    acc,
  output smac_res_t       res
);
  localparam int NOPND = 2;

  logic [NOPND-1:0][W-1:0] src;
  logic [NOPND-1:0]        sel_top;
  logic [NOPND-1:0][W-1:0] ext;
  logic [OP_W-1:0]         hidx;
  logic signed [WIDE-1:0]  wide_v;

  assign src[0] = a;
  assign src[1] = b;

  for (genvar i = 0; i < NOPND; i++) begin : g_pick
    smac_half_pick u_pick (
      .word    (src[i]),
      .take_top(sel_top[i]),
      .ext     (ext[i])
    );
  end

  // Half selection: index within a group of four, bit 1 -> a, bit 0 -> b.
  always_comb begin
    sel_top = '0;
    hidx    = '0;
    if (op >= OP_HMUL_BB && op <= OP_HMUL_TT) hidx = op - OP_HMUL_BB;
    else if (op >= OP_HMAC_BB && op <= OP_HMAC_TT) hidx = op - OP_HMAC_BB;
    sel_top[0] = hidx[1];
    sel_top[1] = (op == OP_WMAC_T) ? 1'b1 : hidx[0];
  end

  always_comb begin
    wide_v = '0;
    res    = '0;
    case (op)
      OP_MUL: begin
        wide_v = f_mul(a, b);
        res.lo = wide_v[W-1:0];
      end
      OP_HMUL_BB, OP_HMUL_BT, OP_HMUL_TB, OP_HMUL_TT: begin
        wide_v = f_mul(ext[0], ext[1]);
        res.lo = wide_v[W-1:0];
      end
      OP_HMAC_BB, OP_HMAC_BT, OP_HMAC_TB, OP_HMAC_TT: begin
        wide_v  = f_hmac(ext[0], ext[1], acc);
        res.lo  = wide_v[W-1:0];
        res.ovf = f_ovf(wide_v);
      end
      OP_WMAC_B, OP_WMAC_T: begin
        wide_v  = f_wmac(a, ext[1], acc);
        res.lo  = wide_v[W-1:0];
        res.ovf = f_ovf(wide_v);
      end
      OP_LMUL: begin
        wide_v = f_mul(a, b);
        res.lo = wide_v[W-1:0];
        res.hi = wide_v[WIDE-1:W];
      end
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/smac_qflag.sv
module smac_qflag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= (flag & ~clr) | set;
  end

  assert_q_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    flag && !clr |=> flag);
  assert_q_clear_R4: assert property (@(posedge clk) disable iff (rst)
    clr && !set |=> !flag);
  assert_q_setwins_R4: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);
endmodule

// File: rtl/smac_unit.sv
module smac_unit
  import smac_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    src_a,
  input  logic [W-1:0]    src_b,
  input  logic [W-1:0]    src_acc,
  input  logic            q_clear,
  output logic            out_valid,
  output logic [W-1:0]    res_lo,
  output logic [W-1:0]    res_hi,
  output logic            q_set,
  output logic            q_flag
);
  smac_res_t core_res;
  logic      ovf_event;

  smac_core u_core (
    .op (op),
    .a  (src_a),
    .b  (src_b),
    .acc(src_acc),
    .res(core_res)
  );

  assign ovf_event = in_valid & core_res.ovf;

  smac_qflag u_q (
    .clk (clk),
    .rst (rst),
    .set (ovf_event),
    .clr (q_clear),
    .flag(q_flag)
  );

  if (REG_OUT) begin : g_reg
    logic [OP_W-1:0] op_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        res_lo    <= '0;
        res_hi    <= '0;
        q_set     <= 1'b0;
        op_q      <= '0;
      end else begin
        out_valid <= in_valid;
        q_set     <= ovf_event;
        if (in_valid) begin
          res_lo <= core_res.lo;
          res_hi <= core_res.hi;
          op_q   <= op;
        end
      end
    end

    assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid && !q_set);
    assert_qset_flag_R3: assert property (@(posedge clk) disable iff (rst)
      q_set |-> q_flag);
    assert_noacc_noq_R1: assert property (@(posedge clk) disable iff (rst)
      out_valid && !f_is_acc(op_q) |-> !q_set);
    assert_hi_zero_R8: assert property (@(posedge clk) disable iff (rst)
      out_valid && op_q != OP_LMUL |-> res_hi == '0);
  end else begin : g_comb
    assign out_valid = in_valid;
    assign res_lo    = core_res.lo;
    assign res_hi    = core_res.hi;
    assign q_set     = ovf_event;
  end
endmodule

// File: tb/sim_smac_unit.sv
module sim_smac_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  op;
  logic [31:0] src_a, src_b, src_acc;
  logic        q_clear;
  logic        out_valid, q_set, q_flag;
  logic [31:0] res_lo, res_hi;

  int n_checks = 0;
  int n_fail   = 0;
  bit model_q  = 1'b0;

  typedef struct {
    logic [31:0] lo;
    logic [31:0] hi;
    logic        qs;
    logic        qf;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  smac_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .src_acc(src_acc), .q_clear(q_clear),
    .out_valid(out_valid), .res_lo(res_lo), .res_hi(res_hi),
    .q_set(q_set), .q_flag(q_flag)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic longint half_of(input logic [31:0] v, input bit top);
    logic [15:0] h;
    h = top ? v[31:16] : v[15:0];
    return longint'($signed(h));
  endfunction

  function automatic bit out_of_int(input longint v);
    return v != longint'($signed(v[31:0]));
  endfunction

  // Reference model: computes expected results in plain 64-bit arithmetic.
  task automatic issue(input logic [3:0] o, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] c,
                       input bit clr, input string req);
    exp_t   e;
    longint sa, sb_, sc, v;
    bit     ov;
    sa = longint'($signed(a));
    sb_ = longint'($signed(b));
    sc = longint'($signed(c));
    v = 0; ov = 0; e.hi = 0;
    if (o == 0) v = sa * sb_;
    else if (o >= 1 && o <= 4)
      v = half_of(a, ((o - 1) >> 1) & 1) * half_of(b, (o - 1) & 1);
    else if (o >= 5 && o <= 8) begin
      v = half_of(a, ((o - 5) >> 1) & 1) * half_of(b, (o - 5) & 1) + sc;
      ov = out_of_int(v);
    end else if (o == 9 || o == 10) begin
      v = (sa * half_of(b, o == 10) + sc * 65536) >>> 16;
      ov = out_of_int(v);
    end else if (o == 11) begin
      v = sa * sb_;
      e.hi = v[63:32];
    end
    e.lo = v[31:0];
    e.qs = ov;
    model_q = (model_q & !clr) | ov;
    e.qf = model_q;
    e.req = req;
    @(negedge clk);
    in_valid = 1'b1; op = o; src_a = a; src_b = b; src_acc = c; q_clear = clr;
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1'b0; q_clear = 1'b0;
  endtask

  // Monitor: compares each delivered result with the oldest expectation.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        check("R9", "unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.req, "res_lo", res_lo, e.lo);
        check(e.req == "R6" ? "R6" : "R8", "res_hi", res_hi, e.hi);
        check(e.req == "R3" ? "R3" : e.req, "q_set", q_set, e.qs);
        check("R4", "q_flag", q_flag, e.qf);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check("WATCHDOG", "timeout", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 0; op = 0; src_a = 0; src_b = 0; src_acc = 0; q_clear = 0;
    repeat (3) @(negedge clk);
    check("R10", "out_valid", out_valid, 0);
    check("R10", "q_flag", q_flag, 0);
    check("R10", "q_set", q_set, 0);
    check("R10", "res_lo", res_lo, 0);
    check("R10", "res_hi", res_hi, 0);
    rst = 1'b0;

    // R7 plain multiply
    issue(4'd0, 32'd1234, 32'd5678, 0, 0, "R7");
    issue(4'd0, 32'hFFFF_FFFD, 32'h1234_5678, 0, 0, "R7");
    issue(4'd0, 32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 0, "R7");
    // R1 halfword multiplies with differing halves
    for (int k = 1; k <= 4; k++) begin
      issue(4'(k), 32'hFFFE_0003, 32'h0005_FFF9, 32'h7FFF_FFFF, 0, "R1");
      issue(4'(k), 32'h8000_7FFF, 32'h8000_8000, 0, 0, "R1");
    end
    // R2 accumulate halfword, no overflow
    for (int k = 5; k <= 8; k++) begin
      issue(4'(k), 32'h0007_FFFD, 32'hFFF0_0011, 32'hFFFF_FF00, 0, "R2");
      issue(4'(k), 32'h1234_8765, 32'hABCD_0042, 32'd1000, 0, "R2");
    end
    check("R4", "flag still clear", q_flag, 0);
    // R3 overflow: 0x8000*0x8000 + max positive
    issue(4'd5, 32'h0000_8000, 32'h0000_8000, 32'h7FFF_FFFF, 0, "R3");
    // R4 sticky across non-overflowing ops
    issue(4'd6, 32'd3, 32'h0002_0000, 32'd7, 0, "R4");
    issue(4'd11, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, "R4");
    // R4 clear alone
    @(negedge clk); q_clear = 1'b1; model_q = 0;
    @(negedge clk); q_clear = 1'b0;
    check("R4", "flag after clear", q_flag, 0);
    // R3 negative overflow, top/top
    issue(4'd8, 32'h8000_0000, 32'h7FFF_0000, 32'h8000_0000, 0, "R3");
    // R4 clear coinciding with an overflow: set wins
    issue(4'd7, 32'h8000_0000, 32'h0000_8000, 32'h7FFF_FFFF, 1, "R4");
    issue(4'd1, 32'd2, 32'd3, 0, 1, "R4");
    // R5 word x halfword
    issue(4'd9, 32'h0012_3456, 32'hFFFF_FFFE, 32'h1234_5678, 0, "R5");
    issue(4'd10, 32'hFFF0_0000, 32'h0003_FFFF, 32'hFFFF_8000, 0, "R5");
    issue(4'd9, 32'h4000_0000, 32'h0000_0004, 32'h0001_0000, 0, "R5");
    issue(4'd10, 32'h7FFF_FFFF, 32'h7FFF_0000, 32'h7FFF_FFFF, 0, "R3");
    // R6 long multiply
    issue(4'd11, 32'h8000_0000, 32'h8000_0000, 0, 0, "R6");
    issue(4'd11, 32'hFFFF_FFFF, 32'h0000_0003, 0, 0, "R6");
    issue(4'd11, 32'h1234_5678, 32'h9ABC_DEF0, 0, 0, "R6");
    // R8 unused opcodes
    for (int k = 12; k <= 15; k++)
      issue(4'(k), 32'hFFFF_FFFF, 32'h8000_8000, 32'h7FFF_FFFF, 0, "R8");
    repeat (3) @(negedge clk);
    check("R9", "queue drained", sb.size(), 0);
    check("R9", "idle out_valid", out_valid, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule